// File: doc/BRIEF.md
# Multi-Requester Exclusive Reservation Monitor

This block fronts a small shared word memory used by several requesters that need lock-free read-modify-write sequences. Each requester may issue a plain read, a plain write, a reserving read or a conditional write. A reserving read returns the word and leaves a reservation for that requester on that address. A conditional write is carried out only if that reservation is still live. It returns a status word: zero means the write happened, one means it was dropped.

Every requester keeps its own reservation flag and tagged address, so several requesters can hold reservations at the same moment. Any write that lands on an address clears the matching reservations of all other requesters. A requester that loses the race sees a failed status and retries its read-modify-write loop. One request is accepted per cycle by a round-robin arbiter, or by a fixed-priority arbiter when the `ARB_RR` parameter is 0. The response comes one cycle after acceptance and carries the requester number.

Top module: `excl_mon`

## Requirements
- R1: After reset every requester's reservation is cleared (Open), `rsp_valid` is low and all memory words read zero. A conditional write issued right after reset fails.
- R2: A plain read (op code 0) returns the addressed word and changes no reservation.
- R3: A reserving read (op code 2) returns the addressed word and leaves the requester reserved (Exclusive) on that address.
- R4: A conditional write (op code 3) whose requester is reserved on the same address writes the word and returns status 0. The requester's reservation is then cleared, so an immediate second conditional write fails.
- R5: A conditional write without a matching live reservation writes nothing and returns status 1. A mismatch on the address also clears the requester's reservation.
- R6: A plain write or a successful conditional write clears the reservation of every other requester tagged on that address. Reservations on other addresses are kept.
- R7: Several requesters can hold reservations at once, including on the same address.
- R8: A new reserving read by a requester replaces its earlier tag. Only one reservation is held per requester.
- R9: At most one `req_ready` bit is high in a cycle, and only for a requester with `req_valid` high. The response is presented in the next cycle with `rsp_id` equal to the accepted requester, and `rsp_valid` is low after any cycle with no acceptance.
- R10: With `ARB_RR`=1, the search starts at the requester after the last one accepted and wraps around. After reset the search starts at requester 0.
- R11: A plain write (op code 1) always writes the word and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request valid, one bit per requester |
| req_op | input | 2*N_REQ | Op code per requester: 0 read, 1 write, 2 reserving read, 3 conditional write |
| req_addr | input | AW*N_REQ | Word address per requester |
| req_wdata | input | DW*N_REQ | Write data per requester |
| req_ready | output | N_REQ | Request accepted this cycle (one-hot or zero) |
| rsp_valid | output | 1 | Response valid |
| rsp_id | output | $clog2(N_REQ) | Requester the response belongs to |
| rsp_data | output | DW | Read data, or status (0 success, 1 failure) for a conditional write |

## Verification
The bench aims at the ways a reservation can be lost:
- another requester writing the same word,
- a conditional write to a different address,
- a second conditional write after a success,
- a newer reserving read replacing the tag.

A design that left a reservation armed in any of these cases would report success and overwrite a newer value. The bench also checks that writes to other words leave a reservation intact; a design that cleared too much would make correct sequences fail. Contending retry loops from all requesters increment one counter, and the final value must equal the number of reported successes; lost updates or phantom successes show up there. Round-robin order is compared every cycle, so a stuck or mis-rotated pointer shows as a wrong `req_ready`.

// File: rtl/excl_pkg.sv
package excl_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_LDEX  = 2'd2,
      OP_STEX  = 2'd3
   } op_e;
endpackage

// File: rtl/excl_arb.sv
module excl_arb #(
   parameter int N_REQ  = 4,
   parameter bit ARB_RR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] valid,
   output logic [N_REQ-1:0] gnt
);
   localparam int IW = $clog2(N_REQ);

   logic [IW-1:0] last_q;
   logic [IW-1:0] gnt_enc;

   generate
      if (ARB_RR) begin : g_rr
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            for (int k = 1; k <= N_REQ; k++) begin
               int idx;
               idx = (int'(last_q) + k) % N_REQ;
               if (!found && valid[idx]) begin
                  gnt[idx] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end else begin : g_fixed
         always_comb begin
            logic found;
            found = 1'b0;
            gnt   = '0;
            for (int k = 0; k < N_REQ; k++) begin
               if (!found && valid[k]) begin
                  gnt[k] = 1'b1;
                  found  = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_comb begin
      gnt_enc = '0;
      for (int i = 0; i < N_REQ; i++)
         if (gnt[i]) gnt_enc = IW'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       last_q <= IW'(N_REQ - 1);
      else if (|gnt)    last_q <= gnt_enc;
   end
endmodule

// File: rtl/excl_resv.sv
module excl_resv
   import excl_pkg::*;
#(
   parameter int N_REQ = 4,
   parameter int AW    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     act,
   input  logic [$clog2(N_REQ)-1:0] id,
   input  op_e                      op,
   input  logic [AW-1:0]            addr,
   output logic                     stex_ok,
   output logic                     mem_we,
   output logic [N_REQ-1:0]         resv_v
);
   logic [AW-1:0] tag_q [N_REQ];

   assign stex_ok = resv_v[id] && (tag_q[id] == addr);
   assign mem_we  = act && ((op == OP_STORE) || (op == OP_STEX && stex_ok));

   generate
      for (genvar j = 0; j < N_REQ; j++) begin : g_slot
         logic self;
         assign self = act && (id == ($clog2(N_REQ))'(j));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               resv_v[j] <= 1'b0;
               tag_q[j]  <= '0;
            end else if (self && op == OP_LDEX) begin
               resv_v[j] <= 1'b1;
               tag_q[j]  <= addr;
            end else if (self && op == OP_STEX) begin
               resv_v[j] <= 1'b0;
            end else if (!self && mem_we && tag_q[j] == addr) begin
               resv_v[j] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/excl_mem.sv
module excl_mem #(
   parameter int AW = 4,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   assign rdata = mem_q[addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[addr] <= wdata;
      end
   end
endmodule

// File: rtl/excl_mon.sv
module excl_mon
   import excl_pkg::*;
#(
   parameter int N_REQ  = 4,
   parameter int AW     = 4,
   parameter int DW     = 32,
   parameter bit ARB_RR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_REQ-1:0]         req_valid,
   input  logic [2*N_REQ-1:0]       req_op,
   input  logic [AW*N_REQ-1:0]      req_addr,
   input  logic [DW*N_REQ-1:0]      req_wdata,
   output logic [N_REQ-1:0]         req_ready,
   output logic                     rsp_valid,
   output logic [$clog2(N_REQ)-1:0] rsp_id,
   output logic [DW-1:0]            rsp_data
);
   localparam int IW = $clog2(N_REQ);

   if (N_REQ < 2)  begin : g_bad_n  $error("N_REQ must be at least 2");  end
   if (AW < 1 || AW > 12) begin : g_bad_aw $error("AW must be 1..12"); end
   if (DW < 2)     begin : g_bad_dw $error("DW must be at least 2");     end

   logic [IW-1:0]    gnt_idx;
   logic             gnt_any;
   op_e              sel_op;
   logic [AW-1:0]    sel_addr;
   logic [DW-1:0]    sel_wdata;
   logic [DW-1:0]    rd_word;
   logic             stex_ok;
   logic             mem_we;
   logic [N_REQ-1:0] resv_v;

   excl_arb #(.N_REQ(N_REQ), .ARB_RR(ARB_RR)) u_arb (
      .clk(clk), .rst_n(rst_n), .valid(req_valid), .gnt(req_ready)
   );

   always_comb begin
      gnt_idx = '0;
      for (int i = 0; i < N_REQ; i++)
         if (req_ready[i]) gnt_idx = IW'(i);
   end

   assign gnt_any   = |req_ready;
   assign sel_op    = op_e'(req_op[{gnt_idx, 1'b0} +: 2]);
   assign sel_addr  = req_addr[int'(gnt_idx)*AW +: AW];
   assign sel_wdata = req_wdata[int'(gnt_idx)*DW +: DW];

   excl_resv #(.N_REQ(N_REQ), .AW(AW)) u_resv (
      .clk(clk), .rst_n(rst_n), .act(gnt_any), .id(gnt_idx), .op(sel_op),
      .addr(sel_addr), .stex_ok(stex_ok), .mem_we(mem_we), .resv_v(resv_v)
   );

   excl_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(sel_addr),
      .wdata(sel_wdata), .rdata(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= gnt_any;
         if (gnt_any) begin
            rsp_id <= gnt_idx;
            case (sel_op)
               OP_LOAD, OP_LDEX: rsp_data <= rd_word;
               OP_STORE:         rsp_data <= '0;
               default:          rsp_data <= stex_ok ? '0 : DW'(1);
            endcase
         end
      end
   end
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk
   import excl_pkg::*;
#(
   parameter int N_REQ = 4,
   parameter int DW    = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_REQ-1:0]         req_valid,
   input logic [2*N_REQ-1:0]       req_op,
   input logic [N_REQ-1:0]         req_ready,
   input logic                     rsp_valid,
   input logic [$clog2(N_REQ)-1:0] rsp_id,
   input logic [DW-1:0]            rsp_data,
   input logic [$clog2(N_REQ)-1:0] gnt_idx,
   input logic [N_REQ-1:0]         resv_v
);
   op_e  g_op;
   logic g_any;
   assign g_op  = op_e'(req_op[{gnt_idx, 1'b0} +: 2]);
   assign g_any = |req_ready;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready)); // R9
   AST_GRANT_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready & ~req_valid) == '0); // R9
   AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      g_any |=> (rsp_valid && rsp_id == $past(gnt_idx))); // R9
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !g_any |=> !rsp_valid); // R9
   AST_LDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (g_any && g_op == OP_LDEX) |=> resv_v[$past(gnt_idx)]); // R3
   AST_STEX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (g_any && g_op == OP_STEX) |=> !resv_v[$past(gnt_idx)]); // R4
   AST_STEX_UNARMED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (g_any && g_op == OP_STEX && !resv_v[gnt_idx]) |=> rsp_data != '0); // R5
   AST_STORE_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (g_any && g_op == OP_STORE) |=> rsp_data == '0); // R11
endmodule

bind excl_mon excl_mon_chk #(.N_REQ(N_REQ), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
   .rsp_data(rsp_data), .gnt_idx(gnt_idx), .resv_v(resv_v)
);

// File: tb/excl_mon_bench.sv
module excl_mon_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int IW = 2;
   localparam int DEPTH = 16;
   localparam int CNT_ADDR = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      req_valid = '0;
   logic [2*N-1:0]    req_op = '0;
   logic [AW*N-1:0]   req_addr = '0;
   logic [DW*N-1:0]   req_wdata = '0;
   logic [N-1:0]      req_ready;
   logic              rsp_valid;
   logic [IW-1:0]     rsp_id;
   logic [DW-1:0]     rsp_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   excl_mon #(.N_REQ(N), .AW(AW), .DW(DW), .ARB_RR(1'b1)) u_excl_mon (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model
   int unsigned m_mem [DEPTH];
   bit          m_rv  [N];
   int          m_rt  [N];
   int          m_last;
   // drive arrays
   bit          d_v [N];
   int          d_op [N];
   int          d_a [N];
   int unsigned d_wd [N];
   // last step results
   int          s_gnt;
   int unsigned s_data;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string op_req(input int op, input bit ok);
      case (op)
         0: return "R2";
         1: return "R11";
         2: return "R3";
         default: return ok ? "R4" : "R5";
      endcase
   endfunction

   task automatic step();
      int g;
      int unsigned data;
      bit ok;
      logic [N-1:0] exp_rdy;
      for (int i = 0; i < N; i++) begin
         req_valid[i]          = d_v[i];
         req_op[2*i +: 2]      = 2'(d_op[i]);
         req_addr[AW*i +: AW]  = AW'(d_a[i]);
         req_wdata[DW*i +: DW] = d_wd[i];
      end
      #1;
      g = -1;
      for (int k = 1; k <= N; k++) begin
         int idx;
         idx = (m_last + k) % N;
         if (g < 0 && d_v[idx]) g = idx;
      end
      exp_rdy = '0;
      if (g >= 0) exp_rdy[g] = 1'b1;
      chk(req_ready == exp_rdy, "R10", "req_ready", req_ready, exp_rdy);
      ok = 0;
      data = 0;
      if (g >= 0) begin
         int a;
         a = d_a[g];
         case (d_op[g])
            0: data = m_mem[a];
            1: begin
               m_mem[a] = d_wd[g];
               for (int j = 0; j < N; j++) if (j != g && m_rt[j] == a) m_rv[j] = 0;
            end
            2: begin data = m_mem[a]; m_rv[g] = 1; m_rt[g] = a; end
            default: begin
               ok = m_rv[g] && m_rt[g] == a;
               data = ok ? 0 : 1;
               m_rv[g] = 0;
               if (ok) begin
                  m_mem[a] = d_wd[g];
                  for (int j = 0; j < N; j++) if (j != g && m_rt[j] == a) m_rv[j] = 0;
               end
            end
         endcase
         m_last = g;
      end
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid == (g >= 0), "R9", "rsp_valid", rsp_valid, g >= 0);
      if (g >= 0) begin
         chk(rsp_id == IW'(g), "R9", "rsp_id", rsp_id, g);
         chk(rsp_data == data, op_req(d_op[g], ok), "rsp_data", rsp_data, data);
      end
      s_gnt = g;
      s_data = data;
   endtask

   task automatic clear_drive();
      for (int i = 0; i < N; i++) begin d_v[i] = 0; d_op[i] = 0; d_a[i] = 0; d_wd[i] = 0; end
   endtask

   task automatic one(input int r, input int op, input int a, input int unsigned wd);
      clear_drive();
      d_v[r] = 1; d_op[r] = op; d_a[r] = a; d_wd[r] = wd;
      step();
      clear_drive();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL R9 watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int st [N];
      int unsigned val [N];
      int succ [N];
      int total;
      int cyc;
      bit all_done;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
      for (int i = 0; i < N; i++) begin m_rv[i] = 0; m_rt[i] = 0; end
      m_last = N - 1;
      clear_drive();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

      // R1: conditional write right after reset fails, nothing written
      one(0, 3, 3, 32'h55);
      chk(s_data == 1, "R1", "stex after reset status", s_data, 1);
      one(1, 0, 3, 0);
      chk(s_data == 0, "R1", "word after reset", s_data, 0);

      // R11 / R2
      one(1, 1, 2, 32'hA5);
      one(1, 0, 2, 0);
      chk(s_data == 32'hA5, "R2", "read back", s_data, 32'hA5);

      // R7 / R6: two holders on one word, first writer wins
      one(0, 2, 2, 0);
      one(2, 2, 2, 0);
      one(2, 3, 2, 7);
      chk(s_data == 0, "R7", "second holder succeeds", s_data, 0);
      one(0, 3, 2, 9);
      chk(s_data == 1, "R6", "cleared by other writer", s_data, 1);
      one(3, 0, 2, 0);
      chk(s_data == 7, "R6", "word kept", s_data, 7);

      // R4: success then reservation gone
      one(0, 2, 4, 0);
      one(0, 3, 4, 32'h11);
      chk(s_data == 0, "R4", "stex ok", s_data, 0);
      one(0, 3, 4, 32'h22);
      chk(s_data == 1, "R4", "second stex fails", s_data, 1);

      // R5: address mismatch fails and disarms
      one(1, 2, 6, 0);
      one(1, 3, 7, 32'h33);
      chk(s_data == 1, "R5", "mismatch fails", s_data, 1);
      one(1, 3, 6, 32'h34);
      chk(s_data == 1, "R5", "disarmed by mismatch", s_data, 1);

      // R8: replacement of tag
      one(2, 2, 8, 0);
      one(2, 2, 9, 0);
      one(2, 3, 8, 32'h44);
      chk(s_data == 1, "R8", "old tag gone", s_data, 1);
      one(2, 2, 8, 0);
      one(2, 2, 9, 0);
      one(2, 3, 9, 32'h45);
      chk(s_data == 0, "R8", "new tag live", s_data, 0);

      // R6: plain write to same word clears, other words do not
      one(3, 2, 10, 0);
      one(0, 1, 11, 32'h66);
      one(3, 3, 10, 32'h77);
      chk(s_data == 0, "R6", "unrelated write keeps reservation", s_data, 0);
      one(0, 2, 12, 0);
      one(3, 1, 12, 32'h88);
      one(0, 3, 12, 32'h99);
      chk(s_data == 1, "R6", "plain write clears", s_data, 1);

      // R10: all requesters contend, hold until accepted
      clear_drive();
      for (int i = 0; i < N; i++) begin d_v[i] = 1; d_op[i] = 0; d_a[i] = i; end
      for (int n = 0; n < N; n++) begin
         int expg;
         expg = (m_last + 1) % N;
         step();
         chk(s_gnt == expg, "R10", "rotation order", s_gnt, expg);
         if (s_gnt >= 0) d_v[s_gnt] = 0;
      end
      clear_drive();
      step();

      // contended retry loops on one counter (R4, R6)
      for (int i = 0; i < N; i++) begin st[i] = 0; val[i] = 0; succ[i] = 0; end
      cyc = 0;
      all_done = 0;
      while (!all_done && cyc < 4000) begin
         for (int i = 0; i < N; i++) begin
            d_v[i] = (succ[i] < 15) && ($urandom % 4 != 0);
            d_a[i] = CNT_ADDR;
            d_op[i] = (st[i] == 0) ? 2 : 3;
            d_wd[i] = val[i];
         end
         step();
         if (s_gnt >= 0) begin
            if (st[s_gnt] == 0) begin
               val[s_gnt] = s_data + 1;
               st[s_gnt] = 1;
            end else begin
               if (s_data == 0) succ[s_gnt]++;
               st[s_gnt] = 0;
            end
         end
         all_done = 1;
         for (int i = 0; i < N; i++) if (succ[i] < 15) all_done = 0;
         cyc++;
      end
      total = 0;
      for (int i = 0; i < N; i++) total += succ[i];
      chk(all_done, "R4", "retry loops completed", all_done, 1);
      one(0, 0, CNT_ADDR, 0);
      chk(s_data == total, "R4", "final count equals successes", s_data, total);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule